// File: doc/BRIEF.md
# Register-Mapped Signed Divider

This block is a small memory-mapped arithmetic unit that performs signed integer division on behalf of a processor. Software loads a divisor and then starts a divide with a single register write. Which register is written selects the operation. A write to one slot divides that value, as a single word, by the divisor. A write to another slot takes the written value as the low half of a double-width dividend, and an earlier write to a further slot supplies the high half.

While the divide runs, the unit raises `busy` and ignores all register writes. The unit uses a restoring divider that handles one dividend bit per clock. When it finishes, the quotient and remainder land in fixed result slots, each in two copies, and all slots change on the same clock edge. A quotient that cannot be held in one signed word saturates to the nearest signed limit. A zero divisor clears the result slots in a single cycle. The register interface is a plain word-wide write port with a combinational read port. There are no wait states, so software polls `busy` before it reads results.

Top module: `mm_sdiv`

## Requirements
- R1: After reset every register slot reads zero and `busy` is low.
- R2: While idle, word-aligned writes to byte offsets 0x00, 0x10, 0x18 and 0x1C store the written value, and reads return it. Offsets 0x08 and 0x0C read zero. A misaligned write has no effect, and a misaligned read returns zero.
- R3: Writing offset 0x04 stores the value and starts a signed single-word divide of that value by the word at 0x00. The quotient truncates toward zero and goes to 0x04, 0x14 and 0x1C. The remainder takes the dividend's sign and goes to 0x10 and 0x18.
- R4: Writing offset 0x14 starts a signed double-word divide. The dividend is {word at 0x10, written value}. The remainder goes to 0x10 and 0x18 and the quotient to 0x14 and 0x1C. Offset 0x04 is left unchanged.
- R5: If a quotient needs more than W signed bits, it saturates. A positive quotient becomes 2^(W-1)-1 and a negative one becomes -2^(W-1). This also covers the single-word case of the most negative value divided by -1.
- R6: With a zero divisor, offsets 0x10, 0x14, 0x18 and 0x1C all become zero. After a single-word start, 0x04 keeps the written dividend. `busy` stays high for exactly one cycle.
- R7: `busy` rises in the cycle after the start write. For a nonzero divisor it stays high for exactly 2*W+1 cycles. All result slots take their new values on the edge where `busy` falls.
- R8: While `busy` is high, writes to any offset are ignored. A write to a start offset does not begin a new divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed slot |
| addr | input | 5 | Byte offset of the accessed slot |
| wrData | input | W | Write data |
| rdData | output | W | Combinational read data of the addressed slot |
| busy | output | 1 | High while a divide is in progress |

## Verification
The bench builds the unit with W=6. At that width, every pair of single-word dividend and divisor can be swept, so the whole single-word operand space is covered, including the most negative dividend divided by -1 and every sign combination. For double-width divides, the bench fixes the high half at four values chosen to reach both saturation directions and the ordinary range. It sweeps every divisor against a spread of low halves. The latency of 2*W+1 cycles is 13 at this width, which keeps the full sweep short.

// File: rtl/mm_sdiv_pkg.sv
package mm_sdiv_pkg;
  localparam int ADDR_W = 5;

  // word index (byte offset / 4) of each slot; the start action keys on these
  localparam logic [2:0] IDX_DIVISOR = 3'd0;
  localparam logic [2:0] IDX_DVD     = 3'd1;
  localparam logic [2:0] IDX_HI      = 3'd4;
  localparam logic [2:0] IDX_LO      = 3'd5;
  localparam logic [2:0] IDX_REMM    = 3'd6;
  localparam logic [2:0] IDX_QUOM    = 3'd7;

  typedef struct packed {
    logic load;    // capture operands
    logic step;    // one restoring iteration
    logic finish;  // commit quotient and remainder
    logic clear;   // commit zero-divisor result
  } divStrobes_t;
endpackage

// File: rtl/mm_sdiv_ctrl.sv
module mm_sdiv_ctrl
  import mm_sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        divZero,
  output divStrobes_t strb,
  output logic        busy
);
  localparam int STEPS = 2 * W;
  localparam int CNT_W = $clog2(STEPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_FIN, S_ZERO} state_t;

  state_t           state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          state   <= divZero ? S_ZERO : S_CALC;
          stepCnt <= CNT_W'(STEPS);
        end
        S_CALC: begin
          stepCnt <= stepCnt - CNT_W'(1);
          if (stepCnt == CNT_W'(1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == S_IDLE) && startReq;
    strb.step   = (state == S_CALC);
    strb.finish = (state == S_FIN);
    strb.clear  = (state == S_ZERO);
    busy        = (state != S_IDLE);
  end
endmodule

// File: rtl/mm_sdiv_dp.sv
module mm_sdiv_dp
  import mm_sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wrData,
  input  logic              busy,
  input  divStrobes_t       strb,
  output logic [W-1:0]      rdData,
  output logic              startReq,
  output logic              divZero
);
  localparam int NW = 2 * W;
  localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

  logic [2:0] idx;
  logic       aligned, wrOk;

  logic [W-1:0] divisorR, dvdR, hiR, loR, remMR, quoMR;

  logic          mode64R, negQ, negR;
  logic [W-1:0]  dMagR;
  logic [W:0]    partR;
  logic [NW-1:0] quoAcc;

  logic [NW-1:0] nFull, nMag;
  logic [W-1:0]  dMagNext;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;
  logic          take;
  logic          ovf;
  logic [W-1:0]  qSigned, qFinal, rMag, rFinal;

  assign idx      = addr[4:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign wrOk     = wrEn && !busy && aligned;
  assign startReq = wrOk && ((idx == IDX_DVD) || (idx == IDX_LO));
  assign divZero  = (divisorR == '0);

  // operand preparation at start
  always_comb begin
    nFull    = (idx == IDX_LO) ? {hiR, wrData} : {{W{wrData[W-1]}}, wrData};
    nMag     = nFull[NW-1] ? (-nFull) : nFull;
    dMagNext = divisorR[W-1] ? (-divisorR) : divisorR;
  end

  // one restoring iteration
  always_comb begin
    shifted = {partR[W-1:0], quoAcc[NW-1]};
    diff    = {1'b0, shifted} - {2'b00, dMagR};
    take    = !diff[W+1];
  end

  // sign fix-up and saturation
  always_comb begin
    if (negQ)
      ovf = (|quoAcc[NW-1:W]) || (quoAcc[W-1] && (|quoAcc[W-2:0]));
    else
      ovf = |quoAcc[NW-1:W-1];
    qSigned = negQ ? (-quoAcc[W-1:0]) : quoAcc[W-1:0];
    qFinal  = ovf ? (negQ ? SAT_MIN : SAT_MAX) : qSigned;
    rMag    = partR[W-1:0];
    rFinal  = negR ? (-rMag) : rMag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisorR <= '0;
      dvdR     <= '0;
      hiR      <= '0;
      loR      <= '0;
      remMR    <= '0;
      quoMR    <= '0;
      mode64R  <= 1'b0;
      negQ     <= 1'b0;
      negR     <= 1'b0;
      dMagR    <= '0;
      partR    <= '0;
      quoAcc   <= '0;
    end else begin
      if (wrOk) begin
        case (idx)
          IDX_DIVISOR: divisorR <= wrData;
          IDX_DVD:     dvdR     <= wrData;
          IDX_HI:      hiR      <= wrData;
          IDX_LO:      loR      <= wrData;
          IDX_REMM:    remMR    <= wrData;
          IDX_QUOM:    quoMR    <= wrData;
          default: ;
        endcase
      end
      if (strb.load) begin
        mode64R <= (idx == IDX_LO);
        negQ    <= nFull[NW-1] ^ divisorR[W-1];
        negR    <= nFull[NW-1];
        dMagR   <= dMagNext;
        partR   <= '0;
        quoAcc  <= nMag;
      end
      if (strb.step) begin
        partR  <= take ? diff[W:0] : shifted;
        quoAcc <= {quoAcc[NW-2:0], take};
      end
      if (strb.finish) begin
        hiR   <= rFinal;
        remMR <= rFinal;
        loR   <= qFinal;
        quoMR <= qFinal;
        if (!mode64R) dvdR <= qFinal;
      end
      if (strb.clear) begin
        hiR   <= '0;
        remMR <= '0;
        loR   <= '0;
        quoMR <= '0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (aligned) begin
      case (idx)
        IDX_DIVISOR: rdData = divisorR;
        IDX_DVD:     rdData = dvdR;
        IDX_HI:      rdData = hiR;
        IDX_LO:      rdData = loR;
        IDX_REMM:    rdData = remMR;
        IDX_QUOM:    rdData = quoMR;
        default:     rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/mm_sdiv.sv
module mm_sdiv
  import mm_sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [4:0]   addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         busy
);
  divStrobes_t strb;
  logic        startReq;
  logic        divZero;

  mm_sdiv_ctrl #(.W(W)) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .divZero  (divZero),
    .strb     (strb),
    .busy     (busy)
  );

  mm_sdiv_dp #(.W(W)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .busy     (busy),
    .strb     (strb),
    .rdData   (rdData),
    .startReq (startReq),
    .divZero  (divZero)
  );
endmodule

// File: rtl/mm_sdiv_chk.sv
module mm_sdiv_chk
  import mm_sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [4:0]  addr,
  input logic        busy,
  input divStrobes_t strb,
  input logic        divZero
);
  localparam int LAT   = 2 * W + 1;
  localparam int CNT_W = $clog2(LAT + 2) + 1;

  logic             startSeen;
  logic [CNT_W-1:0] busyCnt;

  assign startSeen = wrEn && !busy && (addr[1:0] == 2'b00) &&
                     ((addr[4:2] == IDX_DVD) || (addr[4:2] == IDX_LO));

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + CNT_W'(1);
    else           busyCnt <= '0;
  end

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> busy);

  // R6
  zero_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen && divZero) |=> busy ##1 !busy);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == CNT_W'(LAT) || busyCnt == CNT_W'(1)));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step, strb.finish, strb.clear}));

  // R7
  step_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step || strb.finish || strb.clear) |-> busy);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |-> !strb.load);
endmodule

bind mm_sdiv mm_sdiv_chk #(.W(W)) chkI (.*);

// File: tb/tb_mm_sdiv.sv
module tb_mm_sdiv;
  localparam int W     = 6;
  localparam longint SMAX = (64'sd1 <<< (W - 1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (W - 1));
  localparam int LAT   = 2 * W + 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [4:0]   addr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         busy;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  mm_sdiv #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input longint got, input longint exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic checkReg(input string tag, input logic [4:0] a,
                          input logic [W-1:0] exp);
    addr = a;
    #1;
    nChecks++;
    if (rdData !== exp) begin
      nFail++;
      $display("FAIL %s offset %0h: got %0h expected %0h", tag, a, rdData, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (busy) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  // expected results from the requirements
  task automatic expectResult(input longint n, input longint d, input bit mode64,
                              input logic [W-1:0] written, input int cycles);
    longint q, r;
    logic [W-1:0] qe, re;
    string tag;
    tag = mode64 ? "R4" : "R3";
    if (d == 0) begin
      checkVal("R6", "latency", cycles, 1);
      checkReg("R6", 5'h10, '0);
      checkReg("R6", 5'h14, '0);
      checkReg("R6", 5'h18, '0);
      checkReg("R6", 5'h1C, '0);
      if (!mode64) checkReg("R6", 5'h04, written);
    end else begin
      checkVal("R7", "latency", cycles, LAT);
      q = n / d;
      r = n % d;
      if (q > SMAX) begin q = SMAX; tag = "R5"; end
      if (q < SMIN) begin q = SMIN; tag = "R5"; end
      qe = q[W-1:0];
      re = r[W-1:0];
      checkReg(tag, 5'h10, re);
      checkReg(tag, 5'h18, re);
      checkReg(tag, 5'h14, qe);
      checkReg(tag, 5'h1C, qe);
      if (!mode64) checkReg(tag, 5'h04, qe);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [W-1:0] hiVals [4];
    hiVals[0] = 6'b100000; hiVals[1] = 6'b111111;
    hiVals[2] = 6'b000000; hiVals[3] = 6'b000011;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVal("R1", "busy", busy, 0);
    for (int i = 0; i < 8; i++) checkReg("R1", 5'(i * 4), '0);

    // R2 plain register access
    wr(5'h00, 6'd9);  wr(5'h10, 6'd5);  wr(5'h18, 6'd7);  wr(5'h1C, 6'd11);
    wr(5'h08, 6'd3);  wr(5'h0C, 6'd4);  wr(5'h01, 6'd60);
    checkReg("R2", 5'h00, 6'd9);
    checkReg("R2", 5'h10, 6'd5);
    checkReg("R2", 5'h18, 6'd7);
    checkReg("R2", 5'h1C, 6'd11);
    checkReg("R2", 5'h08, '0);
    checkReg("R2", 5'h0C, '0);
    checkReg("R2", 5'h01, '0);
    checkVal("R2", "busy after misaligned", busy, 0);

    // R8 writes during busy are ignored
    wr(5'h00, 6'd7);
    wr(5'h04, 6'd20);
    wr(5'h00, 6'd3);
    wr(5'h04, 6'd1);
    wr(5'h18, 6'd33);
    waitIdle(cyc);
    checkReg("R8", 5'h00, 6'd7);
    checkReg("R8", 5'h04, 6'd2);
    checkReg("R8", 5'h18, 6'd6);
    checkVal("R8", "busy", busy, 0);

    // R3 / R5 / R6 exhaustive single-word sweep
    for (int dv = 0; dv < 64; dv++) begin
      wr(5'h00, 6'(dv));
      for (int nv = 0; nv < 64; nv++) begin
        wr(5'h04, 6'(nv));
        waitIdle(cyc);
        expectResult(sx(6'(nv)), sx(6'(dv)), 1'b0, 6'(nv), cyc);
      end
    end

    // R4 / R5 / R6 double-word sweep
    for (int h = 0; h < 4; h++) begin
      for (int dv = 0; dv < 64; dv++) begin
        wr(5'h00, 6'(dv));
        for (int k = 0; k < 16; k++) begin
          logic [W-1:0] lo;
          lo = 6'(k * 4 + (k % 4));
          wr(5'h10, hiVals[h]);
          wr(5'h14, lo);
          waitIdle(cyc);
          expectResult(sx(hiVals[h]) * 64 + longint'(lo), sx(6'(dv)), 1'b1, lo, cyc);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule